// File: doc/BRIEF.md
# Display-Synchronous I/O Wait-State Generator

This block tells the bus master how many wait cycles to insert for each 8-bit I/O access. A free-running position counter follows where the current clock falls inside a repeating display line period of 2112 clocks. When an access targets video memory, the block looks up a wait count from one of four timing tables. The table is chosen by the text-column mode (40 or 80 columns) and by the resolution mode (standard or high). The lookup index is the counter position plus any clocks already spent by a DMA transfer, wrapped back into the period.

When an access does not target video memory, the wait depends only on the address page. Three slow peripheral pages always get one wait cycle, and every other page gets none.

The wait tables are a parameter ROM computed by a package function. The default contents are a simple test pattern, and real timing values can be substituted at build time.

Top module: `ws_wait_gen`

## Requirements
- R1: While `rst_n` is low, `wait_cnt` is 0 and the position counter is 0. After reset is released, an access strobed in the first cycle sees position 0.
- R2: The position counter advances by one on every clock. After 2111 it returns to 0.
- R3: On a clock edge where `acc_stb` is high, `wait_cnt` loads the wait count for that access, so the result is visible one cycle after the strobe. On every other edge `wait_cnt` holds its value, whatever the other inputs do.
- R4: For a video memory access, the table index is (position + `dma_extra`) mod 2112, where position is the counter value at the strobe edge. `dma_extra` must be below 2112.
- R5: The table is selected by the mode code m = {`hires`, col40}: 0 = 80-column standard, 1 = 40-column standard, 2 = 80-column high resolution, 3 = 40-column high resolution. In the default ROM, entry i of table m is ((i mod 16) + ((i div 256) mod 16)) mod 16, XOR (4·m).
- R6: col40 is bit 6 of `mode_word`. The other seven bits of `mode_word` have no effect on `wait_cnt`.
- R7: For an access with `vram_hit` low, the wait is 1 when `acc_addr[15:8]` is 0x19, 0x1B or 0x1C.
- R8: For an access with `vram_hit` low to any other page, the wait is 0.
- R9: When `vram_hit` is high, the table value is used even if the address falls in a slow page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_stb | input | 1 | Access strobe, high for one cycle per bus access |
| acc_addr | input | 16 | I/O address of the access |
| vram_hit | input | 1 | The access targets video memory |
| mode_word | input | 8 | Display control word; bit 6 selects 40-column mode |
| hires | input | 1 | High-resolution display timing is active |
| dma_extra | input | 12 | Clocks already consumed by DMA, added to the position (below 2112) |
| wait_cnt | output | 4 | Registered wait-cycle count for the last strobed access |

## Verification
Video memory accesses are made in all four mode codes and at many counter positions. A wrong table choice or a wrong index shows up as a value that differs from the test pattern.

Accesses at position 2111, and then at position 0, separate a correct wrap from a counter that runs past 2112. A large DMA offset near the end of the period separates a wrapped index from an unwrapped one.

Non-video accesses to the three slow pages, to their neighbouring pages and to unrelated pages separate the one-cycle rule from the zero rule. A video memory hit on a slow page shows that the table takes precedence.

`mode_word` values with every other bit set show that only bit 6 is decoded. Idle cycles with changing inputs show that the output holds.

// File: rtl/ws_pkg.sv
package ws_pkg;

  // Mode code = {hires, col40}
  typedef enum logic [1:0] {
    MODE_80_STD = 2'b00,
    MODE_40_STD = 2'b01,
    MODE_80_HI  = 2'b10,
    MODE_40_HI  = 2'b11
  } ws_mode_e;

  localparam int NUM_MODES = 4;
  localparam int NUM_SLOW  = 3;

  // Address pages (bits 15:8) that cost one fixed wait cycle
  localparam logic [7:0] SLOW_PAGES [NUM_SLOW] = '{8'h19, 8'h1B, 8'h1C};

  // Default wait ROM contents: a test pattern that changes with both the
  // low and the high index bits, so that a wrap of the period is visible.
  function automatic logic [3:0] dflt_wait(input logic [1:0] mode,
                                           input logic [15:0] idx);
    logic [3:0] base;
    base = idx[3:0] + idx[11:8];
    return base ^ {mode, 2'b00};
  endfunction

endpackage

// File: rtl/ws_pos_counter.sv
module ws_pos_counter #(
  parameter int PERIOD = 2112,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] pos
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_d;

  always_comb begin
    if (pos_q == LAST) pos_d = '0;
    else               pos_d = pos_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);                                                   // R2
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != LAST) |=> (pos_q == $past(pos_q) + CNT_W'(1)));         // R2
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST) |=> (pos_q == '0));                               // R2

endmodule

// File: rtl/ws_page_class.sv
module ws_page_class #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              slow
);

  localparam int PAGE_LSB = ADDR_W - 8;

  logic [ws_pkg::NUM_SLOW-1:0] hit;
  logic                        unused_low;

  for (genvar g = 0; g < ws_pkg::NUM_SLOW; g++) begin : g_page
    assign hit[g] = (addr[ADDR_W-1:PAGE_LSB] == ws_pkg::SLOW_PAGES[g]);
  end

  assign slow       = |hit;
  assign unused_low = ^addr[PAGE_LSB-1:0];

endmodule

// File: rtl/ws_table_rom.sv
module ws_table_rom #(
  parameter int PERIOD = 2112,
  parameter int CNT_W  = $clog2(PERIOD),
  parameter int WAIT_W = 4
) (
  input  logic [CNT_W-1:0]  pos,
  input  logic [CNT_W-1:0]  extra,
  input  ws_pkg::ws_mode_e  mode,
  output logic [WAIT_W-1:0] wait_val
);

  localparam logic [CNT_W:0] PERIOD_W = (CNT_W+1)'(PERIOD);
  localparam int             PAD      = 16 - CNT_W;

  logic [CNT_W:0]    sum;
  logic [CNT_W:0]    wrapped;
  logic [CNT_W-1:0]  idx;
  logic [15:0]       idx16;
  logic [WAIT_W-1:0] tbl [ws_pkg::NUM_MODES];

  // Both operands are below PERIOD, so one subtraction wraps the sum.
  always_comb begin
    sum = {1'b0, pos} + {1'b0, extra};
    if (sum >= PERIOD_W) wrapped = sum - PERIOD_W;
    else                 wrapped = sum;
    idx   = wrapped[CNT_W-1:0];
    idx16 = {{PAD{1'b0}}, idx};
  end

  for (genvar m = 0; m < ws_pkg::NUM_MODES; m++) begin : g_tbl
    assign tbl[m] = WAIT_W'(ws_pkg::dflt_wait(2'(m), idx16));
  end

  assign wait_val = tbl[mode];

  always_comb begin
    if (extra < PERIOD_W[CNT_W-1:0] || PERIOD_W[CNT_W])
      AST_IDX_RANGE: assert ({1'b0, idx} < PERIOD_W);                 // R4
  end

endmodule

// File: rtl/ws_wait_gen.sv
module ws_wait_gen #(
  parameter int PERIOD  = 2112,
  parameter int CNT_W   = $clog2(PERIOD),
  parameter int WAIT_W  = 4,
  parameter int ADDR_W  = 16,
  parameter int MODE_W  = 8,
  parameter int COL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              vram_hit,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              hires,
  input  logic [CNT_W-1:0]  dma_extra,
  output logic [WAIT_W-1:0] wait_cnt
);

  logic [CNT_W-1:0]  pos;
  logic              slow;
  ws_pkg::ws_mode_e  mode;
  logic [WAIT_W-1:0] tbl_wait;
  logic [WAIT_W-1:0] wait_d;
  logic [WAIT_W-1:0] wait_q;
  logic              unused_mode;

  ws_pos_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .pos   (pos)
  );

  ws_page_class #(.ADDR_W(ADDR_W)) u_page (
    .addr (acc_addr),
    .slow (slow)
  );

  assign mode = ws_pkg::ws_mode_e'({hires, mode_word[COL_BIT]});
  assign unused_mode = ^(mode_word & ~(MODE_W'(1) << COL_BIT));

  ws_table_rom #(.PERIOD(PERIOD), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_rom (
    .pos      (pos),
    .extra    (dma_extra),
    .mode     (mode),
    .wait_val (tbl_wait)
  );

  // Next-state: video memory first, then the fixed page rule
  always_comb begin
    wait_d = wait_q;
    if (acc_stb) begin
      if (vram_hit) wait_d = tbl_wait;
      else          wait_d = WAIT_W'(slow);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

  assign wait_cnt = wait_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |=> $stable(wait_cnt));                                  // R3
  AST_SLOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !vram_hit && slow) |=> (wait_cnt == WAIT_W'(1)));     // R7
  AST_FAST_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !vram_hit && !slow) |=> (wait_cnt == '0));            // R8
  AST_VRAM_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && vram_hit) |=> (wait_cnt == $past(tbl_wait)));         // R9

endmodule

// File: tb/ws_wait_gen_test.sv
`timescale 1ns/1ps
module ws_wait_gen_test;

  localparam int PER = 2112;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_stb;
  logic [15:0] acc_addr;
  logic        vram_hit;
  logic [7:0]  mode_word;
  logic        hires;
  logic [11:0] dma_extra;
  logic [3:0]  wait_cnt;

  int checks = 0;
  int errors = 0;
  int tb_pos;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ws_wait_gen uut (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_addr(acc_addr),
    .vram_hit(vram_hit), .mode_word(mode_word), .hires(hires),
    .dma_extra(dma_extra), .wait_cnt(wait_cnt)
  );

  // Bench copy of the line position, taken from the requirement
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_pos <= 0;
    else        tb_pos <= (tb_pos == PER - 1) ? 0 : tb_pos + 1;
  end

  typedef struct packed {
    logic [7:0]  idle;
    logic [15:0] addr;
    logic        vram;
    logic [7:0]  word;
    logic        hi;
    logic [11:0] extra;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'd3,  16'h0123, 1'b1, 8'h00, 1'b0, 12'd0},
    '{8'd7,  16'h4000, 1'b1, 8'h40, 1'b0, 12'd0},
    '{8'd1,  16'h8abc, 1'b1, 8'h00, 1'b1, 12'd5},
    '{8'd20, 16'hc001, 1'b1, 8'h40, 1'b1, 12'd300},
    '{8'd0,  16'h1900, 1'b0, 8'h40, 1'b0, 12'd0},
    '{8'd2,  16'h1b7f, 1'b0, 8'h00, 1'b1, 12'd9},
    '{8'd4,  16'h1cff, 1'b0, 8'h40, 1'b1, 12'd0},
    '{8'd1,  16'h1a01, 1'b0, 8'h00, 1'b0, 12'd0},
    '{8'd0,  16'h1d00, 1'b0, 8'hff, 1'b1, 12'd0},
    '{8'd5,  16'h1800, 1'b0, 8'h40, 1'b0, 12'd0},
    '{8'd2,  16'h1900, 1'b1, 8'h40, 1'b1, 12'd17},
    '{8'd9,  16'h1c10, 1'b1, 8'h00, 1'b0, 12'd1000},
    '{8'd3,  16'h2000, 1'b1, 8'hbf, 1'b0, 12'd0},
    '{8'd6,  16'h2000, 1'b1, 8'hbf, 1'b1, 12'd2111}
  };

  function automatic int ref_wait(logic [15:0] a, logic v, logic [7:0] w,
                                  logic h, int extra, int pos);
    int idx, m;
    if (v) begin
      idx = (pos + extra) % PER;
      m   = (h ? 2 : 0) + (w[6] ? 1 : 0);
      return (((idx % 16) + ((idx / 256) % 16)) % 16) ^ (m * 4);
    end
    if (a[15:8] == 8'h19 || a[15:8] == 8'h1B || a[15:8] == 8'h1C) return 1;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: wait_cnt=%0d expected %0d (pos %0d)", req, act, exp, tb_pos);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the capture
  task automatic access(logic [15:0] a, logic v, logic [7:0] w, logic h,
                        int extra, string req);
    int exp;
    acc_addr = a; vram_hit = v; mode_word = w; hires = h;
    dma_extra = 12'(extra); acc_stb = 1'b1;
    exp = ref_wait(a, v, w, h, extra, tb_pos);
    @(posedge clk);
    @(negedge clk);
    acc_stb = 1'b0;
    check(req, int'(wait_cnt), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acc_stb = 1'b0; acc_addr = '0; vram_hit = 1'b0;
    mode_word = '0; hires = 1'b0; dma_extra = '0;
    repeat (3) @(negedge clk);
    check("R1", int'(wait_cnt), 0);
    rst_n = 1'b1;
    // First access right after release sees position 0: idx 0, mode 3 -> 12
    access(16'h4000, 1'b1, 8'h40, 1'b1, 0, "R1");

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      repeat (int'(VEC[i].idle)) @(negedge clk);
      if (VEC[i].vram)
        tag = (VEC[i].addr[15:8] == 8'h19) ? "R9" : (VEC[i].word == 8'hbf ? "R6" : "R5");
      else if (ref_wait(VEC[i].addr, 1'b0, 8'h00, 1'b0, 0, 0) == 1) tag = "R7";
      else tag = "R8";
      access(VEC[i].addr, VEC[i].vram, VEC[i].word, VEC[i].hi,
             int'(VEC[i].extra), tag);
    end

    // R3: output holds through idle cycles with changing inputs
    access(16'h4003, 1'b1, 8'h00, 1'b1, 0, "R3");
    begin
      int held;
      held = int'(wait_cnt);
      for (int k = 0; k < 6; k++) begin
        acc_addr = 16'h1900 + 16'(k); vram_hit = k[0]; hires = ~hires;
        mode_word = ~mode_word; dma_extra = 12'(k * 100);
        @(negedge clk);
      end
      check("R3", int'(wait_cnt), held);
    end

    // R2: wrap of the position counter (2111 -> 7, then 0 -> 0)
    while (tb_pos != PER - 1) @(negedge clk);
    access(16'h4000, 1'b1, 8'h00, 1'b0, 0, "R2");
    access(16'h4000, 1'b1, 8'h00, 1'b0, 0, "R2");
    access(16'h4000, 1'b1, 8'h00, 1'b0, 0, "R2");

    // R4: DMA offset pushes the index past the end of the period
    while (tb_pos != 2000) @(negedge clk);
    access(16'h8000, 1'b1, 8'h40, 1'b0, 200, "R4");
    access(16'h8000, 1'b1, 8'h00, 1'b1, 2000, "R4");

    // R6: only bit 6 of the mode word matters
    access(16'h4000, 1'b1, 8'hbf, 1'b1, 0, "R6");
    access(16'h4000, 1'b1, 8'h40, 1'b0, 0, "R6");

    // R1: reset during operation clears the output and the position
    access(16'h4007, 1'b1, 8'h40, 1'b1, 0, "R5");
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", int'(wait_cnt), 0);
    rst_n = 1'b1;
    access(16'h4000, 1'b1, 8'h00, 1'b1, 0, "R1");

    finish_run();
  end

endmodule